// File: doc/BRIEF.md
# Flash Chunk DMA Engine

This block is a register-programmed DMA engine. It copies one chunk of a flash controller's cache buffer to or from system memory for each command. Software loads a memory base address, a flash-side base address and a byte length. It then writes a direction code to the command register. The engine moves the data one 32-bit word at a time. Each word is first fetched from the source port and then stored to the destination port. The engine can optionally reverse the bytes inside every word, for hosts that are big-endian.

When a run ends, the engine posts a two-bit completion code. A level interrupt stays asserted until software writes zero to that code. If the memory port signals an error on any beat, the run ends at once and the error is latched in a separate flag. A dedicated stop register abandons a run at any point. The flash cache and the memory fabric connect through plain request/acknowledge ports.

Top module: `flash_chunk_dma`

## Requirements
- R1: After reset, every register reads zero, except the length register, which reads 512. The interrupt is low and neither port issues a request.
- R2: Command value 0x01 copies from the flash cache to memory. For beat i, the engine reads the flash cache at flash base + 4i, then writes memory at memory base + 4i. Each request is held with a stable address until it is acknowledged, and the word arrives unchanged when swapping is off.
- R3: Command value 0x00 copies from memory to the flash cache. For beat i, the engine reads memory at memory base + 4i, then writes the flash cache at flash base + 4i.
- R4: Status bit 0 (offset 0x18) is 1 from the cycle after an accepted command until the last store is acknowledged. Requests appear only while it is 1.
- R5: Done field bits [1:0] (offset 0x1C) become 01 when a run completes normally. Writing zero clears the field. A nonzero write leaves it unchanged. When a completion and a clear arrive in the same cycle, the completion wins.
- R6: The interrupt output is high exactly while the done field is nonzero.
- R7: When config bit 1 (offset 0x00) is set, each word is stored with its four bytes reversed: byte 0 moves to byte 3.
- R8: The number of beats is the length divided by 4, rounded down. A command whose length gives zero beats sets done to 01 immediately and produces no port traffic.
- R9: A command is ignored while status bit 0 is 1, and it is also ignored while config bit 0 (flash mode) is 0.
- R10: Any write to offset 0x14 makes the engine idle in the next cycle. No further requests are issued and the done field is not changed.
- R11: A memory acknowledge that carries an error ends the run. Done becomes 11, error bit 0 (offset 0x20) becomes 1 and the status drops to 0. The failing beat is not stored. The error bit clears only when zero is written to it.
- R12: Register byte offsets are: config at 0x00 (2 bits), memory address at 0x04 (32 bits), flash address at 0x08 (32 bits), length at 0x0C (12 bits), command at 0x10, stop at 0x14, status at 0x18, done at 0x1C and error at 0x20. Command and stop read back as zero, and an offset that is not listed selects nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 6 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational from reg_addr) |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory access is a write |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_ack | input | 1 | Memory access accepted |
| mem_err | input | 1 | Memory access failed (valid with mem_ack) |
| mem_rdata | input | 32 | Memory read data (valid with mem_ack) |
| fc_req | output | 1 | Flash cache access request |
| fc_we | output | 1 | Flash cache access is a write |
| fc_addr | output | 32 | Flash cache byte address |
| fc_wdata | output | 32 | Flash cache write data |
| fc_ack | input | 1 | Flash cache access accepted |
| fc_rdata | input | 32 | Flash cache read data (valid with fc_ack) |
| irq | output | 1 | Level completion interrupt |

## Verification
The request-hold property assumes that software leaves the memory and flash base registers alone while a run is active. This is because the engine forms each beat address from the live register values. The bench writes those registers only between runs.

The error-capture property assumes that the memory port raises mem_err only together with mem_ack on a pending request. The bench's memory model produces an error only on an acknowledged access to the armed address.

The properties also assume that a stop write and a command write never share a cycle, and the single-port register bus makes this true.

// File: rtl/fcd_pkg.sv
package fcd_pkg;
  // register byte offsets
  localparam int OFS_CFG   = 'h00;
  localparam int OFS_MADDR = 'h04;
  localparam int OFS_FADDR = 'h08;
  localparam int OFS_LEN   = 'h0C;
  localparam int OFS_CMD   = 'h10;
  localparam int OFS_STOP  = 'h14;
  localparam int OFS_STAT  = 'h18;
  localparam int OFS_DONE  = 'h1C;
  localparam int OFS_ERR   = 'h20;

  localparam logic [1:0] DONE_OK  = 2'b01;
  localparam logic [1:0] DONE_BAD = 2'b11;

  typedef enum logic [1:0] {
    XS_IDLE  = 2'd0,
    XS_FETCH = 2'd1,
    XS_STORE = 2'd2
  } xs_t;
endpackage

// File: rtl/fcd_rst_sync.sv
module fcd_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr_q <= 2'b00;
    else        sr_q <= {sr_q[0], 1'b1};
  end

  assign rst_n_sync = sr_q[1];
endmodule

// File: rtl/fcd_swap.sv
module fcd_swap #(
  parameter int DATA_W = 32,
  parameter bit ENABLE = 1'b1
) (
  input  logic [DATA_W-1:0] din,
  input  logic              swap,
  output logic [DATA_W-1:0] dout
);
  localparam int NB = DATA_W / 8;

  generate
    if (ENABLE) begin : g_swap
      logic [DATA_W-1:0] rev;
      for (genvar b = 0; b < NB; b++) begin : g_byte
        assign rev[8*b +: 8] = din[8*(NB-1-b) +: 8];
      end
      assign dout = swap ? rev : din;
    end else begin : g_pass
      logic unused_swap;
      assign unused_swap = swap;
      assign dout = din;
    end
  endgenerate
endmodule

// File: rtl/fcd_regs.sv
module fcd_regs
  import fcd_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int DATA_W      = 32,
  parameter int LEN_W       = 12,
  parameter int RA_W        = 6,
  parameter int CHUNK_BYTES = 512
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [RA_W-1:0]   addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic              busy,
  input  logic              fin,
  input  logic              fin_err,
  output logic              cfg_mode,
  output logic              cfg_swap,
  output logic [ADDR_W-1:0] mem_base,
  output logic [ADDR_W-1:0] fl_base,
  output logic [LEN_W-3:0]  beats,
  output logic              start,
  output logic              start_dir,
  output logic              stop,
  output logic [1:0]        done,
  output logic              err
);
  logic [1:0]        cfg_q;
  logic [ADDR_W-1:0] mb_q, fb_q;
  logic [LEN_W-1:0]  len_q;
  logic [1:0]        done_q, done_d;
  logic              err_q, err_d;

  logic sel_cfg, sel_mb, sel_fb, sel_len, sel_cmd, sel_stop, sel_done, sel_err;
  logic wzero;

  assign sel_cfg  = wr && (addr == RA_W'(OFS_CFG));
  assign sel_mb   = wr && (addr == RA_W'(OFS_MADDR));
  assign sel_fb   = wr && (addr == RA_W'(OFS_FADDR));
  assign sel_len  = wr && (addr == RA_W'(OFS_LEN));
  assign sel_cmd  = wr && (addr == RA_W'(OFS_CMD));
  assign sel_stop = wr && (addr == RA_W'(OFS_STOP));
  assign sel_done = wr && (addr == RA_W'(OFS_DONE));
  assign sel_err  = wr && (addr == RA_W'(OFS_ERR));
  assign wzero    = (wdata == '0);

  // next-state for status fields: completion beats a same-cycle clear
  always_comb begin
    done_d = done_q;
    if (fin)                    done_d = fin_err ? DONE_BAD : DONE_OK;
    else if (sel_done && wzero) done_d = 2'b00;
    err_d = err_q;
    if (fin_err)               err_d = 1'b1;
    else if (sel_err && wzero) err_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= 2'b00;
      mb_q   <= '0;
      fb_q   <= '0;
      len_q  <= LEN_W'(CHUNK_BYTES);
      done_q <= 2'b00;
      err_q  <= 1'b0;
    end else begin
      if (sel_cfg) cfg_q <= wdata[1:0];
      if (sel_mb)  mb_q  <= wdata[ADDR_W-1:0];
      if (sel_fb)  fb_q  <= wdata[ADDR_W-1:0];
      if (sel_len) len_q <= wdata[LEN_W-1:0];
      done_q <= done_d;
      err_q  <= err_d;
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      RA_W'(OFS_CFG):   rdata[1:0]        = cfg_q;
      RA_W'(OFS_MADDR): rdata[ADDR_W-1:0] = mb_q;
      RA_W'(OFS_FADDR): rdata[ADDR_W-1:0] = fb_q;
      RA_W'(OFS_LEN):   rdata[LEN_W-1:0]  = len_q;
      RA_W'(OFS_STAT):  rdata[0]          = busy;
      RA_W'(OFS_DONE):  rdata[1:0]        = done_q;
      RA_W'(OFS_ERR):   rdata[0]          = err_q;
      default:          rdata             = '0;
    endcase
  end

  assign cfg_mode  = cfg_q[0];
  assign cfg_swap  = cfg_q[1];
  assign mem_base  = mb_q;
  assign fl_base   = fb_q;
  assign beats     = len_q[LEN_W-1:2];
  assign start     = sel_cmd && cfg_q[0] && !busy;
  assign start_dir = wdata[0];
  assign stop      = sel_stop;
  assign done      = done_q;
  assign err       = err_q;
endmodule

// File: rtl/fcd_xfer.sv
module fcd_xfer
  import fcd_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int DATA_W  = 32,
  parameter int LEN_W   = 12,
  parameter bit SWAP_EN = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              start_dir,
  input  logic              stop,
  input  logic              swap,
  input  logic [ADDR_W-1:0] mem_base,
  input  logic [ADDR_W-1:0] fl_base,
  input  logic [LEN_W-3:0]  beats,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_ack,
  input  logic              mem_err,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              fc_req,
  output logic              fc_we,
  output logic [ADDR_W-1:0] fc_addr,
  output logic [DATA_W-1:0] fc_wdata,
  input  logic              fc_ack,
  input  logic [DATA_W-1:0] fc_rdata,
  output logic              busy,
  output logic              fin,
  output logic              fin_err
);
  localparam int BEAT_W = LEN_W - 2;

  xs_t               st_q, st_d;
  logic [BEAT_W-1:0] cnt_q, cnt_d, lim_q, lim_d;
  logic              dir_q, dir_d;   // 1: flash cache -> memory
  logic [DATA_W-1:0] buf_q, src_word, src_sw;
  logic              buf_en;
  logic              src_ack, src_err, dst_ack, dst_err;
  logic [ADDR_W-1:0] offs;

  assign src_ack  = dir_q ? fc_ack  : mem_ack;
  assign src_err  = dir_q ? 1'b0    : mem_err;
  assign dst_ack  = dir_q ? mem_ack : fc_ack;
  assign dst_err  = dir_q ? mem_err : 1'b0;
  assign src_word = dir_q ? fc_rdata : mem_rdata;

  fcd_swap #(.DATA_W(DATA_W), .ENABLE(SWAP_EN)) u_swap (
    .din  (src_word),
    .swap (swap),
    .dout (src_sw)
  );

  always_comb begin
    st_d    = st_q;
    cnt_d   = cnt_q;
    lim_d   = lim_q;
    dir_d   = dir_q;
    buf_en  = 1'b0;
    fin     = 1'b0;
    fin_err = 1'b0;
    case (st_q)
      XS_IDLE: begin
        if (start) begin
          dir_d = start_dir;
          lim_d = beats;
          cnt_d = '0;
          if (beats == '0) fin  = 1'b1;
          else             st_d = XS_FETCH;
        end
      end
      XS_FETCH: begin
        if (src_ack) begin
          if (src_err) begin
            st_d    = XS_IDLE;
            fin     = 1'b1;
            fin_err = 1'b1;
          end else begin
            buf_en = 1'b1;
            st_d   = XS_STORE;
          end
        end
      end
      XS_STORE: begin
        if (dst_ack) begin
          if (dst_err) begin
            st_d    = XS_IDLE;
            fin     = 1'b1;
            fin_err = 1'b1;
          end else if (cnt_q == lim_q - BEAT_W'(1)) begin
            st_d = XS_IDLE;
            fin  = 1'b1;
          end else begin
            cnt_d = cnt_q + BEAT_W'(1);
            st_d  = XS_FETCH;
          end
        end
      end
      default: st_d = XS_IDLE;
    endcase
    if (stop) begin
      st_d    = XS_IDLE;
      fin     = 1'b0;
      fin_err = 1'b0;
      buf_en  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= XS_IDLE;
      cnt_q <= '0;
      lim_q <= '0;
      dir_q <= 1'b0;
      buf_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      lim_q <= lim_d;
      dir_q <= dir_d;
      if (buf_en) buf_q <= src_sw;
    end
  end

  assign offs      = ADDR_W'({cnt_q, 2'b00});
  assign busy      = (st_q != XS_IDLE);
  assign mem_req   = ((st_q == XS_FETCH) && !dir_q) || ((st_q == XS_STORE) && dir_q);
  assign mem_we    = (st_q == XS_STORE) && dir_q;
  assign mem_addr  = mem_base + offs;
  assign mem_wdata = buf_q;
  assign fc_req    = ((st_q == XS_FETCH) && dir_q) || ((st_q == XS_STORE) && !dir_q);
  assign fc_we     = (st_q == XS_STORE) && !dir_q;
  assign fc_addr   = fl_base + offs;
  assign fc_wdata  = buf_q;
endmodule

// File: rtl/flash_chunk_dma.sv
module flash_chunk_dma #(
  parameter int ADDR_W      = 32,
  parameter int DATA_W      = 32,
  parameter int LEN_W       = 12,
  parameter int RA_W        = 6,
  parameter int CHUNK_BYTES = 512,
  parameter bit SWAP_EN     = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [RA_W-1:0]   reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_ack,
  input  logic              mem_err,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              fc_req,
  output logic              fc_we,
  output logic [ADDR_W-1:0] fc_addr,
  output logic [DATA_W-1:0] fc_wdata,
  input  logic              fc_ack,
  input  logic [DATA_W-1:0] fc_rdata,
  output logic              irq
);
  logic              rst_n_i;
  logic              busy, fin, fin_err, start, start_dir, stop;
  logic              cfg_mode, cfg_swap, err_q;
  logic [1:0]        done_q;
  logic [ADDR_W-1:0] mem_base, fl_base;
  logic [LEN_W-3:0]  beats;

  fcd_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_i)
  );

  fcd_regs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LEN_W(LEN_W),
    .RA_W(RA_W), .CHUNK_BYTES(CHUNK_BYTES)
  ) u_regs (
    .clk       (clk),
    .rst_n     (rst_n_i),
    .wr        (reg_wr),
    .addr      (reg_addr),
    .wdata     (reg_wdata),
    .rdata     (reg_rdata),
    .busy      (busy),
    .fin       (fin),
    .fin_err   (fin_err),
    .cfg_mode  (cfg_mode),
    .cfg_swap  (cfg_swap),
    .mem_base  (mem_base),
    .fl_base   (fl_base),
    .beats     (beats),
    .start     (start),
    .start_dir (start_dir),
    .stop      (stop),
    .done      (done_q),
    .err       (err_q)
  );

  fcd_xfer #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LEN_W(LEN_W), .SWAP_EN(SWAP_EN)
  ) u_xfer (
    .clk       (clk),
    .rst_n     (rst_n_i),
    .start     (start),
    .start_dir (start_dir),
    .stop      (stop),
    .swap      (cfg_swap),
    .mem_base  (mem_base),
    .fl_base   (fl_base),
    .beats     (beats),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_ack   (mem_ack),
    .mem_err   (mem_err),
    .mem_rdata (mem_rdata),
    .fc_req    (fc_req),
    .fc_we     (fc_we),
    .fc_addr   (fc_addr),
    .fc_wdata  (fc_wdata),
    .fc_ack    (fc_ack),
    .fc_rdata  (fc_rdata),
    .busy      (busy),
    .fin       (fin),
    .fin_err   (fin_err)
  );

  assign irq = (done_q != 2'b00);
endmodule

// File: rtl/fcd_checker.sv
module fcd_checker #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int RA_W   = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr,
  input logic [RA_W-1:0]   reg_addr,
  input logic [DATA_W-1:0] reg_wdata,
  input logic              mem_req,
  input logic              mem_ack,
  input logic              mem_err,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              fc_req,
  input logic              irq,
  input logic              busy,
  input logic              fin,
  input logic [1:0]        done_q,
  input logic              err_q,
  input logic              cfg_mode
);
  logic stop_wr, cmd_wr, clr_done;
  assign stop_wr  = reg_wr && (reg_addr == RA_W'('h14));
  assign cmd_wr   = reg_wr && (reg_addr == RA_W'('h10));
  assign clr_done = reg_wr && (reg_addr == RA_W'('h1C)) && (reg_wdata == '0);

  // R4
  req_needs_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req || fc_req) |-> busy);

  // R2
  one_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_req && fc_req));

  // R2
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack && !stop_wr) |=> (mem_req && $stable(mem_addr)));

  // R10
  stop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_wr |=> (!busy && !mem_req && !fc_req));

  // R11
  err_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_ack && mem_err && !stop_wr) |=> (err_q && !busy && done_q == 2'b11));

  // R5
  fin_posts_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(busy) && !$past(stop_wr)) |-> (done_q != 2'b00));

  // R6
  clear_drops_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_done && !fin) |=> !irq);

  // R9
  mode_off_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && !cfg_mode && !busy) |=> !busy);
endmodule

bind flash_chunk_dma fcd_checker #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .RA_W(RA_W)
) u_fcd_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .reg_wr    (reg_wr),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata),
  .mem_req   (mem_req),
  .mem_ack   (mem_ack),
  .mem_err   (mem_err),
  .mem_addr  (mem_addr),
  .fc_req    (fc_req),
  .irq       (irq),
  .busy      (busy),
  .fin       (fin),
  .done_q    (done_q),
  .err_q     (err_q),
  .cfg_mode  (cfg_mode)
);

// File: tb/test_flash_chunk_dma.sv
module test_flash_chunk_dma;
  localparam int A_CFG = 'h00, A_MB = 'h04, A_FB = 'h08, A_LEN = 'h0C, A_CMD = 'h10,
                 A_STOP = 'h14, A_STAT = 'h18, A_DONE = 'h1C, A_ERR = 'h20;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_wr;
  logic [5:0]  reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic        mem_req, mem_we, mem_ack, mem_err;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic        fc_req, fc_we, fc_ack;
  logic [31:0] fc_addr, fc_wdata, fc_rdata;
  logic        irq;

  int n_chk = 0, n_err = 0, n_mem_wr = 0, n_fc_wr = 0;
  logic stall = 1'b0, err_arm = 1'b0, sb_on = 1'b1;
  logic [31:0] err_addr = '0;
  logic [63:0] exp_q[$];

  always #4 clk = ~clk;

  flash_chunk_dma i_flash_chunk_dma (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_err(mem_err), .mem_rdata(mem_rdata),
    .fc_req(fc_req), .fc_we(fc_we), .fc_addr(fc_addr), .fc_wdata(fc_wdata),
    .fc_ack(fc_ack), .fc_rdata(fc_rdata), .irq(irq)
  );

  function automatic logic [31:0] fl_pat(input logic [31:0] a);
    return {a[15:0] ^ 16'hC3A5, a[31:16] ^ a[15:0]};
  endfunction
  function automatic logic [31:0] mem_pat(input logic [31:0] a);
    return (a * 32'h9E37_79B9) ^ 32'h5A5A_0F0F;
  endfunction
  function automatic logic [31:0] bswap(input logic [31:0] d, input logic en);
    return en ? {d[7:0], d[15:8], d[23:16], d[31:24]} : d;
  endfunction

  // port models: acknowledge on the falling edge, optionally stalled
  always @(negedge clk) begin
    fc_ack    = fc_req && (!stall || ($urandom_range(0, 2) != 0));
    fc_rdata  = fl_pat(fc_addr);
    mem_ack   = mem_req && (!stall || ($urandom_range(0, 2) != 0));
    mem_rdata = mem_pat(mem_addr);
    mem_err   = mem_ack && err_arm && (mem_addr == err_addr);
  end

  // monitor: pops the scoreboard on every accepted destination store
  always @(negedge clk) begin
    #1;
    if (rst_n && mem_ack && mem_we && !mem_err) begin
      n_mem_wr++;
      if (sb_on) sb_cmp({mem_addr, mem_wdata});
    end
    if (rst_n && fc_ack && fc_we) begin
      n_fc_wr++;
      if (sb_on) sb_cmp({fc_addr, fc_wdata});
    end
  end

  task automatic sb_cmp(input logic [63:0] got);
    logic [63:0] e;
    n_chk++;
    if (exp_q.size() == 0) begin
      n_err++;
      $display("FAIL R2/R3 scoreboard: act=%h exp=<none>", got);
    end else begin
      e = exp_q.pop_front();
      if (got !== e) begin
        n_err++;
        $display("FAIL R2/R3 scoreboard: act=%h exp=%h", got, e);
      end
    end
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic reg_write(input int a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 6'(a); reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic reg_read(input int a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = 6'(a);
    #1 d = reg_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] s;
    s = 32'd1;
    for (int i = 0; i < 4000 && s[0]; i++) reg_read(A_STAT, s);
  endtask

  // driver: program a run and push the expected stores
  task automatic drive(input logic rd, input logic [31:0] mb, input logic [31:0] fb,
                       input int len, input int n_push, input logic swp);
    reg_write(A_MB, mb);
    reg_write(A_FB, fb);
    reg_write(A_LEN, 32'(len));
    for (int i = 0; i < n_push; i++) begin
      if (rd) exp_q.push_back({mb + 32'(4*i), bswap(fl_pat(fb + 32'(4*i)), swp)});
      else    exp_q.push_back({fb + 32'(4*i), bswap(mem_pat(mb + 32'(4*i)), swp)});
    end
    reg_write(A_CMD, {31'd0, rd});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: act=hung exp=finished");
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int mw, fw;
    rst_n = 1'b0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    reg_read(A_CFG, v);  chk("R1 cfg", v, 0);
    reg_read(A_MB, v);   chk("R1 maddr", v, 0);
    reg_read(A_FB, v);   chk("R1 faddr", v, 0);
    reg_read(A_LEN, v);  chk("R1 len", v, 512);
    reg_read(A_STAT, v); chk("R1 status", v, 0);
    reg_read(A_DONE, v); chk("R1 done", v, 0);
    reg_read(A_ERR, v);  chk("R1 err", v, 0);
    chk("R1 irq/req", {29'd0, irq, mem_req, fc_req}, 0);

    // R12 readback widths and offsets
    reg_write(A_MB, 32'h8000_1000); reg_read(A_MB, v); chk("R12 maddr", v, 32'h8000_1000);
    reg_write(A_FB, 32'h0004_0200); reg_read(A_FB, v); chk("R12 faddr", v, 32'h0004_0200);
    reg_write(A_LEN, 32'hFFFF);     reg_read(A_LEN, v); chk("R12 len width", v, 32'hFFF);
    reg_write(A_CFG, 32'hFFFF_FFFF); reg_read(A_CFG, v); chk("R12 cfg width", v, 3);
    reg_read(A_CMD, v);  chk("R12 cmd reads 0", v, 0);
    reg_read('h24, v);   chk("R12 unlisted offset", v, 0);
    reg_write('h05, 32'h1234); reg_read(A_MB, v); chk("R12 unaligned ignored", v, 32'h8000_1000);
    reg_write(A_CFG, 1);

    // R2 full chunk read, no stall, no swap; R4 status while active
    mw = n_mem_wr; fw = n_fc_wr;
    drive(1'b1, 32'h8000_1000, 32'h0000_0200, 512, 128, 1'b0);
    reg_read(A_STAT, v); chk("R4 active after cmd", v, 1);
    wait_idle();
    reg_read(A_STAT, v); chk("R4 idle after run", v, 0);
    chk("R2 queue drained", exp_q.size(), 0);
    chk("R2 memory stores", n_mem_wr - mw, 128);
    chk("R2 no flash stores", n_fc_wr - fw, 0);
    reg_read(A_DONE, v); chk("R5 done ok", v, 1);
    chk("R6 irq set", {31'd0, irq}, 1);
    reg_write(A_DONE, 2); reg_read(A_DONE, v); chk("R5 nonzero write kept", v, 1);
    reg_write(A_DONE, 0); reg_read(A_DONE, v); chk("R5 cleared", v, 0);
    chk("R6 irq clear", {31'd0, irq}, 0);

    // R3 memory to flash with stalls
    stall = 1'b1; mw = n_mem_wr; fw = n_fc_wr;
    drive(1'b0, 32'h1000_0040, 32'h0000_0200, 64, 16, 1'b0);
    wait_idle();
    chk("R3 queue drained", exp_q.size(), 0);
    chk("R3 flash stores", n_fc_wr - fw, 16);
    chk("R3 no memory stores", n_mem_wr - mw, 0);
    reg_write(A_DONE, 0);

    // R7 byte swap both directions
    reg_write(A_CFG, 3);
    drive(1'b1, 32'h2000_0000, 32'h0000_1200, 32, 8, 1'b1);
    wait_idle();
    drive(1'b0, 32'h2000_0100, 32'h0000_1300, 32, 8, 1'b1);
    wait_idle();
    chk("R7 swapped queue drained", exp_q.size(), 0);
    reg_write(A_DONE, 0);
    reg_write(A_CFG, 1);
    stall = 1'b0;

    // R8 truncated length and zero-beat run
    mw = n_mem_wr;
    drive(1'b1, 32'h3000_0000, 32'h0000_0400, 46, 11, 1'b0);
    wait_idle();
    chk("R8 len 46 beats", n_mem_wr - mw, 11);
    reg_write(A_DONE, 0);
    mw = n_mem_wr; fw = n_fc_wr;
    drive(1'b1, 32'h3000_0000, 32'h0000_0400, 3, 0, 1'b0);
    reg_read(A_DONE, v); chk("R8 zero beats done", v, 1);
    reg_read(A_STAT, v); chk("R8 zero beats idle", v, 0);
    repeat (5) @(negedge clk);
    chk("R8 zero beats no traffic", (n_mem_wr - mw) + (n_fc_wr - fw), 0);
    reg_write(A_DONE, 0);

    // R9 command while active and with mode off
    mw = n_mem_wr; fw = n_fc_wr;
    drive(1'b1, 32'h4000_0000, 32'h0000_0600, 64, 16, 1'b0);
    repeat (4) @(negedge clk);
    reg_write(A_CMD, 0);
    wait_idle();
    chk("R9 second cmd ignored", n_fc_wr - fw, 0);
    chk("R9 first run intact", n_mem_wr - mw, 16);
    chk("R9 queue drained", exp_q.size(), 0);
    reg_write(A_DONE, 0);
    reg_write(A_CFG, 0);
    mw = n_mem_wr;
    reg_write(A_CMD, 1);
    reg_read(A_STAT, v); chk("R9 mode off stays idle", v, 0);
    repeat (10) @(negedge clk);
    reg_read(A_DONE, v); chk("R9 mode off no done", v, 0);
    chk("R9 mode off no traffic", n_mem_wr - mw, 0);
    reg_write(A_CFG, 1);

    // R10 stop mid-run
    sb_on = 1'b0;
    drive(1'b1, 32'h5000_0000, 32'h0000_0000, 512, 0, 1'b0);
    repeat (20) @(negedge clk);
    reg_write(A_STOP, 32'hDEAD);
    reg_read(A_STAT, v); chk("R10 idle after stop", v, 0);
    mw = n_mem_wr; fw = n_fc_wr;
    repeat (20) @(negedge clk);
    chk("R10 no traffic after stop", (n_mem_wr - mw) + (n_fc_wr - fw), 0);
    reg_read(A_DONE, v); chk("R10 done untouched", v, 0);
    sb_on = 1'b1;

    // R11 bus error on the sixth memory store
    mw = n_mem_wr;
    err_addr = 32'h6000_0000 + 32'd20; err_arm = 1'b1;
    drive(1'b1, 32'h6000_0000, 32'h0000_0800, 64, 5, 1'b0);
    wait_idle();
    err_arm = 1'b0;
    reg_read(A_DONE, v); chk("R11 done error code", v, 3);
    reg_read(A_ERR, v);  chk("R11 error bit", v, 1);
    chk("R11 stores before error", n_mem_wr - mw, 5);
    chk("R11 queue drained", exp_q.size(), 0);
    chk("R6 irq on error", {31'd0, irq}, 1);
    reg_write(A_ERR, 5); reg_read(A_ERR, v); chk("R11 nonzero keeps error", v, 1);
    reg_write(A_ERR, 0); reg_read(A_ERR, v); chk("R11 error cleared", v, 0);
    reg_write(A_DONE, 0);

    repeat (4) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule